// File: doc/BRIEF.md
# Descriptor ring source engine

This block walks a circular ring of transmit descriptors kept in a small local descriptor memory. The host fills ring slots through a memory write port, then tells the engine how far it may go by writing a write index. The engine picks up every descriptor from its own read index up to that write index. For each one it raises a transfer request carrying the buffer address, byte count, metadata and byte-swap flag. When the request is taken, the engine moves its read index on by one slot.

Several descriptors can form one logical transfer. Each descriptor that carries the gather flag is chained to the next one, and the first descriptor without it closes the chain. The request marks the first and the last segment of each chain. A completion pulse follows only the closing segment, for use by an interrupt block.

The read index is visible on a port at all times, so the host can find finished descriptors whenever it looks. A descriptor whose byte count exceeds the programmed maximum is dropped without a request and sets a sticky error flag. A ring size of zero switches the engine off.

Top module: `dring_src_engine`

## Requirements
- R1: After reset the ring size is 0, so no request is raised. The read index is 0 and both the completion pulse and the error flag are low.
- R2: Each descriptor is one 64-bit word laid out as follows: bits 31:0 hold the buffer address, bits 47:32 the byte count and bits 63:48 the flags. Within the flags, bit 0 is gather, bit 1 is byte swap and bits 15:2 are the metadata. The request presents these fields from the memory slot (base + read index) mod DEPTH.
- R3: A descriptor is pending when the ring size is nonzero and the read index differs from the write index. A request stays raised, with its fields unchanged, until ready is seen. On each accepted request the read index becomes (read index + 1) AND (size − 1).
- R4: A write-index write stores the written value AND (size − 1). The read index port always shows the next descriptor not yet consumed.
- R5: The first flag is high when the previously consumed descriptor had no gather bit, or when nothing has been consumed since reset or the last size write. The last flag is high when the current descriptor has no gather bit.
- R6: The completion pulse is high for exactly one cycle, in the cycle after a descriptor without the gather bit is accepted. Accepting a gather descriptor produces no pulse.
- R7: A pending descriptor whose byte count is greater than the maximum length raises no request and produces no completion pulse. The read index still advances past it, and the error flag goes high in the next cycle and stays high until reset.
- R8: A size of 0 disables the ring. A size write clears the read index, the write index and the chain state to 0, and it takes precedence over an advance in the same cycle.
- R9: When a write-index write lands in the same cycle as an accepted request, both the new write index and the read-index advance take effect.
- R10: The slot address wraps modulo DEPTH, so a ring whose base lies near the end of descriptor memory continues at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 size, 2 maximum length, 3 write index |
| cfg_wdata | input | 16 | Configuration write data |
| dmem_we | input | 1 | Descriptor memory write strobe |
| dmem_addr | input | AW | Descriptor memory slot |
| dmem_wdata | input | 64 | Descriptor word |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Transfer request accepted |
| xfer_addr | output | 32 | Buffer address |
| xfer_len | output | 16 | Byte count |
| xfer_meta | output | 14 | Metadata field |
| xfer_swap | output | 1 | Byte-swap flag |
| xfer_first | output | 1 | First segment of a logical transfer |
| xfer_last | output | 1 | Last segment of a logical transfer |
| rd_idx | output | AW | Live read index |
| cc_pulse | output | 1 | Completion pulse |
| err_oversize | output | 1 | Sticky oversize error |

## Verification
Two events can fall in the same clock edge: a host register write and a descriptor being consumed. The bench provokes this deliberately. It commits a new write index while the ready input is held high on a pending request, and it later writes the ring size during a handshake. A behavioural model applies both effects, with size-write priority, and compares every output at each falling edge. A wrong choice of which event wins therefore appears at once as a mismatch in the read index or the request valid.

// File: rtl/dring_pkg.sv
`timescale 1ns/1ps
package dring_pkg;
  localparam int FLAG_GATHER = 0;
  localparam int FLAG_SWAP   = 1;
  localparam int META_LSB    = 2;
  localparam int META_W      = 14;

  typedef struct packed {
    logic [15:0] flags;
    logic [15:0] len;
    logic [31:0] addr;
  } desc_t;

  typedef enum logic [1:0] {
    CFG_BASE   = 2'd0,
    CFG_SIZE   = 2'd1,
    CFG_MAXLEN = 2'd2,
    CFG_WRIDX  = 2'd3
  } cfg_sel_e;

  function automatic logic [15:0] ring_next(input logic [15:0] idx, input logic [15:0] mask);
    return (idx + 16'd1) & mask;
  endfunction

  function automatic logic [15:0] slot_of(input logic [15:0] base, input logic [15:0] idx,
                                          input logic [15:0] amask);
    return (base + idx) & amask;
  endfunction

  function automatic logic ring_pending(input logic [15:0] size, input logic [15:0] rd,
                                        input logic [15:0] wr);
    return (size != 16'd0) && (rd != wr);
  endfunction

  function automatic logic too_long(input logic [15:0] len, input logic [15:0] maxlen);
    return len > maxlen;
  endfunction
endpackage

// File: rtl/dring_cfg_regs.sv
`timescale 1ns/1ps
module dring_cfg_regs #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [15:0]   cfg_wdata,
  output logic [AW-1:0] base,
  output logic [SW-1:0] size,
  output logic [AW-1:0] mask,
  output logic [15:0]   maxlen,
  output logic [AW-1:0] wr_idx,
  output logic          size_wr
);
  import dring_pkg::*;

  assign mask    = AW'(size - SW'(1));
  assign size_wr = cfg_we && (cfg_sel_e'(cfg_sel) == CFG_SIZE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base   <= '0;
      size   <= '0;
      maxlen <= '0;
      wr_idx <= '0;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        CFG_BASE:   base   <= cfg_wdata[AW-1:0];
        CFG_SIZE: begin
          size   <= cfg_wdata[SW-1:0];
          wr_idx <= '0;
        end
        CFG_MAXLEN: maxlen <= cfg_wdata;
        default:    wr_idx <= cfg_wdata[AW-1:0] & mask;
      endcase
    end
  end

  // R8: a size write always leaves the write index at zero
  p_size_clears_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    size_wr |=> (wr_idx == '0));
endmodule

// File: rtl/dring_desc_mem.sv
`timescale 1ns/1ps
module dring_desc_mem #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  dring_pkg::desc_t   wdata,
  input  logic [AW-1:0]      raddr,
  output dring_pkg::desc_t   rdata
);
  dring_pkg::desc_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dring_seq.sv
`timescale 1ns/1ps
module dring_seq #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] size,
  input  logic [AW-1:0] mask,
  input  logic [AW-1:0] wr_idx,
  input  logic [15:0]   maxlen,
  input  logic          size_wr,
  input  logic [15:0]   d_len,
  input  logic          d_gather,
  input  logic          xfer_ready,
  output logic          xfer_valid,
  output logic          xfer_first,
  output logic          xfer_last,
  output logic [AW-1:0] rd_idx,
  output logic          cc_pulse,
  output logic          err_oversize
);
  import dring_pkg::*;

  logic in_chain;
  logic pending, oversize, fire, skip, advance;
  logic [AW-1:0] rd_next;

  assign pending    = ring_pending(16'(size), 16'(rd_idx), 16'(wr_idx));
  assign oversize   = too_long(d_len, maxlen);
  assign xfer_valid = pending && !oversize;
  assign fire       = xfer_valid && xfer_ready;
  assign skip       = pending && oversize;
  assign advance    = fire || skip;
  assign rd_next    = AW'(ring_next(16'(rd_idx), 16'(mask)));
  assign xfer_first = !in_chain;
  assign xfer_last  = !d_gather;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx       <= '0;
      in_chain     <= 1'b0;
      cc_pulse     <= 1'b0;
      err_oversize <= 1'b0;
    end else begin
      cc_pulse <= fire && !d_gather;
      if (skip) err_oversize <= 1'b1;
      if (size_wr) begin
        rd_idx   <= '0;
        in_chain <= 1'b0;
      end else if (advance) begin
        rd_idx   <= rd_next;
        in_chain <= d_gather;
      end
    end
  end

  // R3: nothing is requested when the ring is empty
  p_no_req_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == wr_idx) |-> !xfer_valid);
  // R3: a stalled request keeps its slot
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready && !size_wr) |=> (xfer_valid && $stable(rd_idx)));
  // R3: each consumed descriptor moves the index by one, wrapped
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !size_wr) |=> (rd_idx == (($past(rd_idx) + AW'(1)) & $past(mask))));
  // R6: a completion follows only an accepted closing segment
  p_cc_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cc_pulse |-> $past(xfer_valid && xfer_ready && xfer_last));
  // R7: an oversize descriptor never shows as a request
  p_skip_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> !xfer_valid);
  // R7: the error flag does not drop
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_oversize |=> err_oversize);
  // R8: a size write returns the read index to zero
  p_size_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    size_wr |=> (rd_idx == '0));
endmodule

// File: rtl/dring_src_engine.sv
`timescale 1ns/1ps
module dring_src_engine #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [15:0]   cfg_wdata,
  input  logic          dmem_we,
  input  logic [AW-1:0] dmem_addr,
  input  logic [63:0]   dmem_wdata,
  output logic          xfer_valid,
  input  logic          xfer_ready,
  output logic [31:0]   xfer_addr,
  output logic [15:0]   xfer_len,
  output logic [13:0]   xfer_meta,
  output logic          xfer_swap,
  output logic          xfer_first,
  output logic          xfer_last,
  output logic [AW-1:0] rd_idx,
  output logic          cc_pulse,
  output logic          err_oversize
);
  import dring_pkg::*;

  logic [AW-1:0] base, mask, wr_idx, slot;
  logic [SW-1:0] size;
  logic [15:0]   maxlen;
  logic          size_wr;
  desc_t         cur;

  dring_cfg_regs #(.DEPTH(DEPTH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .base(base), .size(size), .mask(mask), .maxlen(maxlen), .wr_idx(wr_idx),
    .size_wr(size_wr)
  );

  assign slot = AW'(slot_of(16'(base), 16'(rd_idx), 16'(DEPTH - 1)));

  dring_desc_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(dmem_we), .waddr(dmem_addr), .wdata(desc_t'(dmem_wdata)),
    .raddr(slot), .rdata(cur)
  );

  dring_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .size(size), .mask(mask), .wr_idx(wr_idx),
    .maxlen(maxlen), .size_wr(size_wr), .d_len(cur.len),
    .d_gather(cur.flags[FLAG_GATHER]), .xfer_ready(xfer_ready),
    .xfer_valid(xfer_valid), .xfer_first(xfer_first), .xfer_last(xfer_last),
    .rd_idx(rd_idx), .cc_pulse(cc_pulse), .err_oversize(err_oversize)
  );

  assign xfer_addr = cur.addr;
  assign xfer_len  = cur.len;
  assign xfer_meta = cur.flags[META_LSB +: META_W];
  assign xfer_swap = cur.flags[FLAG_SWAP];

  // R2: a stalled request keeps its fields while the host leaves the ring alone
  p_req_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready && !cfg_we && !dmem_we) |=>
      ($stable(xfer_addr) && $stable(xfer_len) && $stable(xfer_meta)));
endmodule

// File: tb/sim_dring_src_engine.sv
`timescale 1ns/1ps
module sim_dring_src_engine;
  localparam int DEPTH = 32;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          cfg_we = 0;
  logic [1:0]    cfg_sel = 0;
  logic [15:0]   cfg_wdata = 0;
  logic          dmem_we = 0;
  logic [AW-1:0] dmem_addr = 0;
  logic [63:0]   dmem_wdata = 0;
  logic          xfer_ready = 0;
  logic          xfer_valid, xfer_swap, xfer_first, xfer_last, cc_pulse, err_oversize;
  logic [31:0]   xfer_addr;
  logic [15:0]   xfer_len;
  logic [13:0]   xfer_meta;
  logic [AW-1:0] rd_idx;

  dring_src_engine #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
    .xfer_len(xfer_len), .xfer_meta(xfer_meta), .xfer_swap(xfer_swap),
    .xfer_first(xfer_first), .xfer_last(xfer_last), .rd_idx(rd_idx),
    .cc_pulse(cc_pulse), .err_oversize(err_oversize)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_base = 0, m_size = 0, m_maxlen = 0, m_wr = 0, m_rd = 0;
  bit m_chain = 0, m_cc = 0, m_err = 0;
  logic [63:0] m_mem [DEPTH];

  always @(posedge clk) begin : model
    int slot;
    logic [63:0] d;
    bit pend, over, fire, skip;
    if (!rst_n) begin
      m_base = 0; m_size = 0; m_maxlen = 0; m_wr = 0; m_rd = 0;
      m_chain = 0; m_cc = 0; m_err = 0;
    end else begin
      slot = (m_base + m_rd) % DEPTH;
      d    = m_mem[slot];
      pend = (m_size != 0) && (m_rd != m_wr);
      over = int'(d[47:32]) > m_maxlen;
      fire = pend && !over && xfer_ready;
      skip = pend && over;
      m_cc = fire && !d[48];
      if (skip) m_err = 1;
      if (cfg_we && cfg_sel == 2'd1) begin
        m_rd = 0; m_chain = 0;
      end else if (fire || skip) begin
        m_rd = (m_rd + 1) & (m_size - 1);
        m_chain = d[48];
      end
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: m_base = int'(cfg_wdata) & (DEPTH - 1);
          2'd1: begin m_size = int'(cfg_wdata) & (2 * DEPTH - 1); m_wr = 0; end
          2'd2: m_maxlen = int'(cfg_wdata);
          default: m_wr = int'(cfg_wdata) & (m_size - 1) & (DEPTH - 1);
        endcase
      end
      if (dmem_we) m_mem[dmem_addr] = dmem_wdata;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  string phase = "R1";

  task automatic compare();
    int slot;
    logic [63:0] d;
    bit pend, ev;
    slot = (m_base + m_rd) % DEPTH;
    d    = m_mem[slot];
    pend = (m_size != 0) && (m_rd != m_wr);
    ev   = pend && !(int'(d[47:32]) > m_maxlen);
    chk((m_size == 0) ? "R8" : "R3", {phase, " valid"}, xfer_valid, ev);
    chk("R4", {phase, " rd_idx"}, rd_idx, m_rd);
    chk("R6", {phase, " cc_pulse"}, cc_pulse, m_cc);
    chk("R7", {phase, " err"}, err_oversize, m_err);
    if (ev) begin
      chk((m_base + m_rd >= DEPTH) ? "R10" : "R2", {phase, " addr"}, xfer_addr, d[31:0]);
      chk("R2", {phase, " len"}, xfer_len, d[47:32]);
      chk("R2", {phase, " meta"}, xfer_meta, d[63:50]);
      chk("R2", {phase, " swap"}, xfer_swap, d[49]);
      chk("R5", {phase, " first"}, xfer_first, !m_chain);
      chk("R5", {phase, " last"}, xfer_last, !d[48]);
    end
  endtask

  int rmode = 0;
  logic [7:0] lf = 8'h5b;

  task automatic step();
    @(negedge clk);
    compare();
    cfg_we = 0;
    dmem_we = 0;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    case (rmode)
      0: xfer_ready = 1;
      1: xfer_ready = lf[0];
      default: xfer_ready = 0;
    endcase
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  int h_base = 0, h_size = 0, h_wr = 0, seqn = 0;

  task automatic cfg(int sel, int val);
    step();
    cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = 16'(val);
    if (sel == 0) h_base = val & (DEPTH - 1);
    if (sel == 1) begin h_size = val; h_wr = 0; end
  endtask

  task automatic push(int len, bit gather, bit swap);
    while (((h_wr + 1) & (h_size - 1)) == int'(rd_idx)) step();
    step();
    seqn++;
    dmem_we    = 1;
    dmem_addr  = AW'((h_base + h_wr) % DEPTH);
    dmem_wdata = {14'(seqn * 3 + 1), swap, gather, 16'(len), 32'h1000_0000 + 32'(seqn * 64)};
    h_wr = (h_wr + 1) & (h_size - 1);
  endtask

  task automatic commit(int extra);
    cfg(3, h_wr + extra);
  endtask

  initial begin : main
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 64'd0;
    for (int i = 0; i < DEPTH; i++) u0.u_mem.mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state at the ports
    chk("R1", "reset valid", xfer_valid, 0);
    chk("R1", "reset rd_idx", rd_idx, 0);
    chk("R1", "reset cc", cc_pulse, 0);
    chk("R1", "reset err", err_oversize, 0);

    phase = "R2 basic";
    rmode = 0;
    cfg(0, 4); cfg(1, 8); cfg(2, 200);
    push(10, 0, 0); push(20, 0, 1); push(30, 0, 0);
    commit(0);
    run(6);

    phase = "R3 backpressure";
    rmode = 2;
    push(40, 0, 1); push(50, 0, 0);
    commit(0);
    run(5);
    rmode = 1;
    run(12);

    phase = "R5 R6 gather";
    push(11, 1, 0); push(12, 1, 1); push(13, 0, 0);
    push(14, 1, 0); push(15, 0, 1);
    commit(0);
    run(20);

    phase = "R7 oversize";
    push(300, 0, 0); push(16, 0, 0); push(500, 1, 0); push(17, 0, 0);
    commit(0);
    run(12);

    phase = "R9 same cycle";
    rmode = 0;
    push(21, 0, 0); push(22, 0, 0);
    commit(-1);
    push(23, 0, 0);
    commit(0);
    run(8);

    phase = "R4 wrap";
    rmode = 1;
    for (int k = 0; k < 20; k++) begin
      push(k + 1, (k % 4) == 1, k[0]);
      commit(8 * (k % 3));
    end
    run(40);

    phase = "R8 size during handshake";
    rmode = 0;
    push(31, 0, 0); push(32, 0, 0);
    commit(0);
    cfg(1, 4);
    run(4);

    phase = "R10 base wrap";
    rmode = 1;
    cfg(0, 30);
    cfg(1, 4);
    for (int k = 0; k < 7; k++) begin
      push(k + 5, 0, 1);
      commit(0);
    end
    run(30);

    phase = "R8 disabled";
    cfg(1, 0);
    cfg(3, 3);
    run(5);
    chk("R8", "disabled valid", xfer_valid, 0);
    chk("R7", "sticky err after traffic", err_oversize, 1);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule